// File: doc/BRIEF.md
# Programmable sample pulse generator

This block produces the sampling window for a sample-and-hold stage. One of two trigger inputs starts the window on its rising edge. The window then ends in one of three ways, chosen by a 4-bit stop code and a timebase select. With a zero code the window follows the trigger level, but it is never shorter than a minimum number of clock cycles. With a non-zero code the window lasts a fixed number of `clk_i` steps. Otherwise it lasts a number of edges of a slow external clock, which is first brought into the `clk_i` domain through a synchroniser.

The code and the timebase are captured when a window opens, so control writes made during a window apply only to the next one. A one-cycle `done_o` strobe marks the end of every window.

Top module: `sample_pulse_gen`

## Requirements
- R1: `trig_sel_i` = 0 selects `ext_trig_i` and 1 selects `int_trig_i`. Activity on the trigger that is not selected produces no pulse.
- R2: `sample_o` goes high in the cycle after the first rising clock edge at which the selected trigger is sampled high while the block is idle.
- R3: With `stop_code_i` = 0, a trigger that is sampled high for H cycles, where H >= MIN_CYCLES, gives a pulse exactly H cycles wide.
- R4: With `stop_code_i` = 0, a trigger that is high for fewer than MIN_CYCLES cycles gives a pulse exactly MIN_CYCLES cycles wide.
- R5: With a non-zero code C and `clk_sel_i` = 0, the pulse is exactly C*STEP_CYCLES cycles wide, whatever the trigger does.
- R6: With a non-zero code C and `clk_sel_i` = 1, the pulse ends on the C-th rising edge of `ext_clk_i`, counted after synchronisation from the start of the pulse. Each edge counts once. With an external period of T cycles, the width lies between (C-1)*T and C*T+1 cycles.
- R7: A new trigger rising edge that arrives while a pulse is active neither restarts nor extends the pulse.
- R8: `stop_code_i` and `clk_sel_i` are captured when a pulse starts. Changes to them during a pulse do not change that pulse's width.
- R9: `done_o` is high for exactly one cycle: the first cycle in which `sample_o` is low after being high.
- R10: While `rst_ni` is low, `sample_o` and `done_o` are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_trig_i | input | 1 | External trigger |
| int_trig_i | input | 1 | Internal trigger |
| ext_clk_i | input | 1 | Slow external timebase, asynchronous to clk_i |
| trig_sel_i | input | 1 | Trigger source select: 0 external, 1 internal |
| clk_sel_i | input | 1 | Timebase select: 0 clk_i steps, 1 external clock edges |
| stop_code_i | input | 4 | Stop code: 0 follows the trigger level, non-zero sets the width |
| sample_o | output | 1 | Sample window |
| done_o | output | 1 | One-cycle end-of-window strobe |

## Verification
The bench builds the block with STEP_CYCLES = 2 and MIN_CYCLES = 3. With these values every non-zero code fits in a 30-cycle window, so all fifteen codes can be swept, and trigger widths from 1 to 6 cover both the stretched and the level-following cases on each trigger source. A 6-cycle external clock exercises codes 1 to 4 within a bounded width range. The bench also covers re-triggers and mid-pulse control changes, and samples the width and the strobe of every pulse.

// File: rtl/sample_pulse_pkg.sv
package sample_pulse_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_PCLK  = 2'd1,
    MODE_XCLK  = 2'd2
  } win_mode_e;
endpackage

// File: rtl/spg_trig_sel.sv
module spg_trig_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_trig_i,
  input  logic int_trig_i,
  input  logic sel_i,
  output logic level_o,
  output logic rise_o
);
  logic prev_q;

  assign level_o = sel_i ? int_trig_i : ext_trig_i;
  assign rise_o  = level_o & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_o;
  end

  // R2: a detected edge cannot repeat in the next cycle
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/spg_ext_sync.sv
module spg_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[MSB-1:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[MSB];
  end

  assign rise_o = sync_q[MSB] & ~prev_q;

  // R6: each synchronised edge is seen for one cycle only
  p_edge_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/spg_width_ctl.sv
module spg_width_ctl
  import sample_pulse_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4,
  parameter int unsigned MIN_CYCLES  = 30,
  parameter int unsigned CNT_W       = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_lvl_i,
  input  logic       trig_rise_i,
  input  logic       xrise_i,
  input  logic       clk_sel_i,
  input  logic [3:0] code_i,
  output logic       active_o,
  output logic       done_o
);
  logic             active_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       code_q;
  win_mode_e        mode_q;
  logic [CNT_W-1:0] pclk_lim, xclk_lim, min_lim;
  logic             stop;

  assign pclk_lim = CNT_W'(code_q) * CNT_W'(STEP_CYCLES);
  assign xclk_lim = CNT_W'(code_q) - CNT_W'(1);
  assign min_lim  = CNT_W'(MIN_CYCLES);

  always_comb begin
    unique case (mode_q)
      MODE_LEVEL: stop = !trig_lvl_i && (cnt_q >= min_lim);
      MODE_PCLK:  stop = (cnt_q == pclk_lim);
      default:    stop = xrise_i && (cnt_q == xclk_lim);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      code_q   <= '0;
      mode_q   <= MODE_LEVEL;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (trig_rise_i) begin
          active_q <= 1'b1;
          code_q   <= code_i;
          if (code_i == 4'd0)  mode_q <= MODE_LEVEL;
          else if (clk_sel_i)  mode_q <= MODE_XCLK;
          else                 mode_q <= MODE_PCLK;
          cnt_q <= (code_i != 4'd0 && clk_sel_i) ? '0 : CNT_W'(1);
        end
      end else if (stop) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
        cnt_q    <= '0;
      end else if (mode_q == MODE_PCLK) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end else if (mode_q == MODE_LEVEL) begin
        if (cnt_q < min_lim) cnt_q <= cnt_q + CNT_W'(1);
      end else if (xrise_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;

  p_level_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_q == MODE_LEVEL && trig_lvl_i) |=> active_q);
  p_min_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_q == MODE_LEVEL && cnt_q < min_lim) |=> active_q);
  p_no_overrun_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_q == MODE_PCLK) |-> cnt_q <= pclk_lim);
  p_xcount_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && mode_q == MODE_XCLK && !xrise_i) |=> (active_q && $stable(cnt_q)));
endmodule

// File: rtl/sample_pulse_gen.sv
module sample_pulse_gen #(
  parameter int unsigned STEP_CYCLES = 4,
  parameter int unsigned MIN_CYCLES  = 30,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ext_trig_i,
  input  logic       int_trig_i,
  input  logic       ext_clk_i,
  input  logic       trig_sel_i,
  input  logic       clk_sel_i,
  input  logic [3:0] stop_code_i,
  output logic       sample_o,
  output logic       done_o
);
  localparam int unsigned MAX_PCLK = 15 * STEP_CYCLES;
  localparam int unsigned MAX_CNT  = (MAX_PCLK > MIN_CYCLES) ? MAX_PCLK : MIN_CYCLES;
  localparam int unsigned CNT_W    = $clog2(MAX_CNT + 1);

  logic trig_lvl, trig_rise, xrise;

  spg_trig_sel u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_trig_i (ext_trig_i),
    .int_trig_i (int_trig_i),
    .sel_i      (trig_sel_i),
    .level_o    (trig_lvl),
    .rise_o     (trig_rise)
  );

  spg_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_clk_i),
    .rise_o  (xrise)
  );

  spg_width_ctl #(
    .STEP_CYCLES (STEP_CYCLES),
    .MIN_CYCLES  (MIN_CYCLES),
    .CNT_W       (CNT_W)
  ) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_lvl_i  (trig_lvl),
    .trig_rise_i (trig_rise),
    .xrise_i     (xrise),
    .clk_sel_i   (clk_sel_i),
    .code_i      (stop_code_i),
    .active_o    (sample_o),
    .done_o      (done_o)
  );

  p_done_at_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_o) |-> done_o);
  p_done_only_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sample_o && $past(sample_o)));
  p_start_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> $past(trig_lvl));
endmodule

// File: tb/sample_pulse_gen_test.sv
module sample_pulse_gen_test;
  localparam int STEP = 2;
  localparam int MINW = 3;
  localparam int XPER = 6;

  logic clk = 0, rst_ni = 0;
  logic ext_trig = 0, int_trig = 0, ext_clk = 0, trig_sel = 0, clk_sel = 0;
  logic [3:0] code = 0;
  logic sample, done;
  logic xen = 0;

  int checks = 0, errors = 0;
  int run = 0, last_w = 0, pulses = 0, done_cnt = 0;
  logic last_done = 0;

  sample_pulse_gen #(.STEP_CYCLES(STEP), .MIN_CYCLES(MINW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_trig_i(ext_trig), .int_trig_i(int_trig),
    .ext_clk_i(ext_clk), .trig_sel_i(trig_sel), .clk_sel_i(clk_sel),
    .stop_code_i(code), .sample_o(sample), .done_o(done));

  always #5 clk = ~clk;

  initial forever begin
    repeat (XPER/2) @(negedge clk);
    if (xen) ext_clk = ~ext_clk;
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (sample) run++;
    else if (run > 0) begin
      last_w = run; last_done = done; run = 0; pulses++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_trig(input logic v);
    if (trig_sel) int_trig = v; else ext_trig = v;
  endtask

  task automatic fire(input int h);
    @(negedge clk); set_trig(1);
    repeat (h) @(negedge clk);
    set_trig(0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p0, d0;
    repeat (3) @(negedge clk);
    chk("R10 sample in reset", sample, 0);
    chk("R10 done in reset", done, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R2 start latency, R3/R4 level mode on both sources
    for (int s = 0; s < 2; s++) begin
      trig_sel = s[0];
      for (int h = 1; h <= 6; h++) begin
        p0 = pulses; d0 = done_cnt;
        @(negedge clk); set_trig(1);
        @(negedge clk);
        if (h == 1) chk("R2 high after first edge", sample, 1);
        repeat (h-1) @(negedge clk);
        set_trig(0);
        repeat (12) @(negedge clk);
        chk("R3/R4 pulse count", pulses - p0, 1);
        chk(h < MINW ? "R4 stretched width" : "R3 level width", last_w, h < MINW ? MINW : h);
        chk("R9 done at fall", last_done, 1);
        chk("R9 single done", done_cnt - d0, 1);
      end
    end

    // R1 unselected source ignored
    trig_sel = 0; p0 = pulses;
    @(negedge clk); int_trig = 1; repeat (5) @(negedge clk); int_trig = 0;
    repeat (10) @(negedge clk);
    chk("R1 int ignored when ext selected", pulses - p0, 0);
    trig_sel = 1; p0 = pulses;
    @(negedge clk); ext_trig = 1; repeat (5) @(negedge clk); ext_trig = 0;
    repeat (10) @(negedge clk);
    chk("R1 ext ignored when int selected", pulses - p0, 0);

    // R5 sweep all codes, peripheral timebase, long trigger
    trig_sel = 0; clk_sel = 0;
    for (int c = 1; c <= 15; c++) begin
      code = c[3:0]; p0 = pulses;
      fire(40);
      repeat (5) @(negedge clk);
      chk("R5 pulse count", pulses - p0, 1);
      chk("R5 step width", last_w, c * STEP);
    end

    // R7 re-trigger in count mode
    code = 4'd8; p0 = pulses;
    fire(1);
    repeat (2) @(negedge clk); set_trig(1);
    repeat (2) @(negedge clk); set_trig(0);
    repeat (3) @(negedge clk); set_trig(1);
    repeat (1) @(negedge clk); set_trig(0);
    repeat (20) @(negedge clk);
    chk("R7 one pulse", pulses - p0, 1);
    chk("R7 width unchanged", last_w, 8 * STEP);

    // R7 re-trigger in level mode during stretch
    code = 4'd0; p0 = pulses;
    fire(1);
    set_trig(1); @(negedge clk); set_trig(0);
    repeat (12) @(negedge clk);
    chk("R7 level re-trigger one pulse", pulses - p0, 1);
    chk("R7 level re-trigger width", last_w, MINW);

    // R8 control change mid-pulse
    code = 4'd3; clk_sel = 0; p0 = pulses;
    fire(1);
    code = 4'd12; clk_sel = 1;
    repeat (20) @(negedge clk);
    chk("R8 latched width", last_w, 3 * STEP);
    code = 4'd0; clk_sel = 0;
    fire(1);
    code = 4'd9; clk_sel = 0;
    repeat (15) @(negedge clk);
    chk("R8 latched level mode", last_w, MINW);

    // R6 external timebase
    xen = 1; clk_sel = 1;
    repeat (10) @(negedge clk);
    for (int c = 1; c <= 4; c++) begin
      code = c[3:0]; p0 = pulses;
      fire(1);
      repeat (c * XPER + 10) @(negedge clk);
      chk("R6 pulse count", pulses - p0, 1);
      checks++;
      if (last_w < (c-1)*XPER || last_w > c*XPER + 1) begin
        errors++;
        $display("FAIL R6 ext width actual %0d expected %0d..%0d", last_w, (c-1)*XPER, c*XPER+1);
      end
    end
    // R6 stalled external clock holds the pulse
    xen = 0; code = 4'd2; p0 = pulses;
    fire(1);
    repeat (40) @(negedge clk);
    chk("R6 held without ext edges", sample, 1);
    xen = 1;
    repeat (3*XPER + 5) @(negedge clk);
    chk("R6 ends after ext edges", pulses - p0, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule